// File: doc/BRIEF.md
# Interleaved Sampling Phase Generator

This block drives the switch controls of a ten-way time-interleaved sample-and-sum array in which every interleaved block shares one summing amplifier. A one-hot ring of ten stages walks through ten non-overlapping slots. Each slot is one unit delay long and is split into a fixed number of sub-ticks of the block clock. The unit delay is changed only by changing the clock frequency. For every interleaved block the generator decodes nine sampling enables, one per input channel, taken from nine consecutive slots. The slot after those nine is that block's amplification slot.

Successive blocks are offset by one slot, so some block is amplifying in every slot. The amplifying block's slot is also a sampling slot of the other blocks. The shared amplifier is cleared by a reset pulse in the first sub-tick of every slot, and that block's amplification enable covers the remaining sub-ticks. Each sampling enable drops one sub-tick before its slot ends, so a block never holds two channel switches closed at once. A valid strobe marks the settled last sub-tick of an amplification slot. The strobe stays off until the amplifying block has collected all nine samples since reset.

Top module: `interleave_phase_gen`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, the outputs show slot 0 at sub-tick 0. `phase_o` equals 10'b0000000001. `amp_rst_o` is 1, `amp_en_o` is 0 and `valid_o` is 0. The sampling enables that are high are exactly those of slot 0.
- R2: `phase_o` always has exactly one bit set. Bit k moves to bit (k+1) mod 10 once every TICKS clocks (default 4), so the full pattern repeats every 40 clocks.
- R3: Sampling enable `samp_en_o[b*9+c]` (block b in 0..9, channel c in 0..8) is high only while `phase_o` bit (b+c) mod 10 is set. Within that slot it is high in sub-ticks 0 to TICKS-2.
- R4: In the last sub-tick of every slot all sampling enables are low, and no block ever has more than one sampling enable high.
- R5: `amp_en_o[b]` is high while `phase_o` bit (b+9) mod 10 is set, in sub-ticks 1 to TICKS-1. At most one block amplifies at a time.
- R6: `amp_rst_o` is high in sub-tick 0 of every slot, and low otherwise. It is never high together with any `amp_en_o` bit.
- R7: `valid_o` is high in the last sub-tick of a slot, only from slot 9 after reset onward, that is from clock 39 after reset release. It is low in every other clock.
- R8: If the ring holds a state other than one-hot (no bit set, or several bits set), the next clock puts it in slot 0, with `phase_o` equal to 10'b0000000001. The sub-tick count is not affected.
- R9: Raising `rst` in the middle of operation returns all outputs to the R1 state and restarts the valid warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; TICKS periods form one unit-delay slot |
| rst | input | 1 | Synchronous active-high reset |
| phase_o | output | 10 | One-hot base slot phases |
| samp_en_o | output | 90 | Sampling enables, index block*9+channel |
| amp_en_o | output | 10 | Amplification enable, one bit per block |
| amp_rst_o | output | 1 | Shared amplifier reset pulse |
| valid_o | output | 1 | Summed output settled and valid |

## Verification
The bench follows the generator through several full ring revolutions. At every clock it compares all outputs against a slot and sub-tick model. This catches a one-slot error in the block-to-phase mapping, which would close a switch a unit delay early or late. It also catches a guard sub-tick that was lost, which would let two channel switches of one block overlap at a slot boundary. The warm-up window is probed on its exact edge: a design that raised the strobe at once would sum partly empty blocks, and one that started a slot late would drop a valid sample. Illegal ring states with no bit set and with two bits set are injected. A ring without the correction would stop all switching or close switches of two slots at once. A mid-run reset must restart the warm-up from the beginning.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    // Number of interleaved blocks, equal to the number of ring stages.
    localparam int IPG_BLOCKS = 10;
    // Sub-ticks per unit-delay slot; must be at least 2.
    localparam int IPG_TICKS  = 4;

    // Position of a sub-tick inside its slot.
    typedef enum logic [1:0] {
        TK_FIRST = 2'd0,
        TK_MID   = 2'd1,
        TK_LAST  = 2'd2
    } tick_pos_e;

    // Sub-tick status handed from the sub-slot counter to the decoder.
    typedef struct packed {
        tick_pos_e pos;
        logic      adv;
    } tick_info_t;

    // Ring slot used by channel c of block b.
    function automatic int samp_slot(input int b, input int c, input int nblk);
        return (b + c) % nblk;
    endfunction

    // Ring slot in which block b amplifies.
    function automatic int amp_slot(input int b, input int nblk);
        return (b + nblk - 1) % nblk;
    endfunction

endpackage

// File: rtl/ipg_subslot.sv
module ipg_subslot
    import ipg_pkg::*;
#(
    parameter int TICKS = IPG_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    output logic       adv_o,
    output tick_info_t nx_o
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);

    logic [TW-1:0] tick_q;
    logic [TW-1:0] tick_nx;

    assign adv_o = (tick_q == LAST_T);

    always_comb begin
        if (rst || adv_o) tick_nx = '0;
        else              tick_nx = tick_q + TW'(1);
    end

    always_comb begin
        if (tick_nx == '0)          nx_o.pos = TK_FIRST;
        else if (tick_nx == LAST_T) nx_o.pos = TK_LAST;
        else                        nx_o.pos = TK_MID;
        nx_o.adv = (tick_nx == LAST_T);
    end

    always_ff @(posedge clk) begin
        tick_q <= tick_nx;
    end

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q == LAST_T) |=> (tick_q == '0));

endmodule

// File: rtl/ipg_ring.sv
module ipg_ring #(
    parameter int NBLK = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    output logic [NBLK-1:0] ring_nx_o
);
    localparam logic [NBLK-1:0] RING_INIT = NBLK'(1);

    logic [NBLK-1:0] ring_q;
    logic            legal;

    assign legal = ($countones(ring_q) == 1);

    always_comb begin
        if (rst || !legal) ring_nx_o = RING_INIT;
        else if (adv_i)    ring_nx_o = {ring_q[NBLK-2:0], ring_q[NBLK-1]};
        else               ring_nx_o = ring_q;
    end

    always_ff @(posedge clk) begin
        ring_q <= ring_nx_o;
    end

    // R8
    ring_repair_chk: assert property (@(posedge clk) disable iff (rst)
        (!legal) |=> ($countones(ring_q) == 1));

    // R2
    ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (legal && !adv_i) |=> ($stable(ring_q) || $countones(ring_q) != 1));

endmodule

// File: rtl/ipg_warmup.sv
module ipg_warmup #(
    parameter int NBLK = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    output logic warm_nx_o
);
    localparam int CW = $clog2(NBLK);
    localparam logic [CW-1:0] FULL = CW'(NBLK - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        if (rst)                           cnt_nx = '0;
        else if (adv_i && cnt_q != FULL)   cnt_nx = cnt_q + CW'(1);
        else                               cnt_nx = cnt_q;
    end

    assign warm_nx_o = (cnt_nx == FULL);

    always_ff @(posedge clk) begin
        cnt_q <= cnt_nx;
    end

    // R7
    warm_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL) |=> (cnt_q == FULL));

endmodule

// File: rtl/ipg_decode.sv
module ipg_decode
    import ipg_pkg::*;
#(
    parameter int NBLK = IPG_BLOCKS
) (
    input  logic [NBLK-1:0]            ring_i,
    input  tick_pos_e                  pos_i,
    input  logic                       warm_i,
    output logic [NBLK*(NBLK-1)-1:0]   samp_o,
    output logic [NBLK-1:0]            amp_en_o,
    output logic                       amp_rst_o,
    output logic                       valid_o
);
    localparam int NCH = NBLK - 1;

    logic live;
    logic first_t;
    logic last_t;

    assign live    = |ring_i;
    assign first_t = (pos_i == TK_FIRST);
    assign last_t  = (pos_i == TK_LAST);

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int SLOT = samp_slot(b, c, NBLK);
            assign samp_o[b*NCH+c] = ring_i[SLOT] & ~last_t;
        end
        localparam int ASLOT = amp_slot(b, NBLK);
        assign amp_en_o[b] = ring_i[ASLOT] & ~first_t;
    end

    assign amp_rst_o = first_t & live;
    assign valid_o   = last_t & warm_i & live;

endmodule

// File: rtl/interleave_phase_gen.sv
module interleave_phase_gen
    import ipg_pkg::*;
#(
    parameter int NBLK  = IPG_BLOCKS,
    parameter int TICKS = IPG_TICKS
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [NBLK-1:0]           phase_o,
    output logic [NBLK*(NBLK-1)-1:0]  samp_en_o,
    output logic [NBLK-1:0]           amp_en_o,
    output logic                      amp_rst_o,
    output logic                      valid_o
);
    localparam int NCH   = NBLK - 1;
    localparam int SAMPW = NBLK * NCH;

    logic                adv;
    tick_info_t          tk_nx;
    logic [NBLK-1:0]     ring_nx;
    logic                warm_nx;
    logic [SAMPW-1:0]    samp_nx;
    logic [NBLK-1:0]     amp_nx;
    logic                arst_nx;
    logic                valid_nx;

    ipg_subslot #(.TICKS(TICKS)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .adv_o (adv),
        .nx_o  (tk_nx)
    );

    ipg_ring #(.NBLK(NBLK)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .adv_i     (adv),
        .ring_nx_o (ring_nx)
    );

    ipg_warmup #(.NBLK(NBLK)) u_warm (
        .clk       (clk),
        .rst       (rst),
        .adv_i     (adv),
        .warm_nx_o (warm_nx)
    );

    ipg_decode #(.NBLK(NBLK)) u_dec (
        .ring_i    (ring_nx),
        .pos_i     (tk_nx.pos),
        .warm_i    (warm_nx),
        .samp_o    (samp_nx),
        .amp_en_o  (amp_nx),
        .amp_rst_o (arst_nx),
        .valid_o   (valid_nx)
    );

    // Outputs are registered from the decoded next state so that every
    // switch control leaves a flop without decode glitches.
    always_ff @(posedge clk) begin
        phase_o   <= ring_nx;
        samp_en_o <= samp_nx;
        amp_en_o  <= amp_nx;
        amp_rst_o <= arst_nx;
        valid_o   <= valid_nx;
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_chk
        // R4
        samp_excl_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(samp_en_o[b*NCH +: NCH]));
    end

    // R2
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_o) == 1);

    // R6
    rst_amp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        amp_rst_o |-> (amp_en_o == '0));

    // R5
    amp_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(amp_en_o));

    // R7
    valid_amp_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($countones(amp_en_o) == 1 && !amp_rst_o));

    // R4
    guard_tick_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (samp_en_o == '0));

endmodule

// File: tb/test_interleave_phase_gen.sv
module test_interleave_phase_gen;

    localparam int NB  = 10;
    localparam int NC  = 9;
    localparam int TK  = 4;
    localparam int SW  = NB * NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] phase_o;
    logic [SW-1:0] samp_en_o;
    logic [NB-1:0] amp_en_o;
    logic          amp_rst_o;
    logic          valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    int m_ph   = 0;
    int m_tick = 0;
    int m_done = 0;

    always #5 clk = ~clk;

    interleave_phase_gen i_interleave_phase_gen (
        .clk       (clk),
        .rst       (rst),
        .phase_o   (phase_o),
        .samp_en_o (samp_en_o),
        .amp_en_o  (amp_en_o),
        .amp_rst_o (amp_rst_o),
        .valid_o   (valid_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_tick = 0; m_done = 0;
    endtask

    task automatic model_step();
        if (m_tick == TK - 1) begin
            m_tick = 0;
            m_ph   = (m_ph + 1) % NB;
            m_done++;
        end else begin
            m_tick++;
        end
    endtask

    // Compare every output with the model; tags name the requirement.
    task automatic compare(input string ctx);
        logic [NB-1:0] e_ph;
        logic [SW-1:0] e_s;
        logic [NB-1:0] e_a;
        logic          e_r;
        logic          e_v;
        e_ph = '0;
        e_ph[m_ph] = 1'b1;
        e_s = '0;
        e_a = '0;
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < NC; c++)
                if ((b + c) % NB == m_ph && m_tick != TK - 1) e_s[b*NC+c] = 1'b1;
            if ((b + NB - 1) % NB == m_ph && m_tick != 0) e_a[b] = 1'b1;
        end
        e_r = (m_tick == 0);
        e_v = (m_tick == TK - 1) && (m_done >= NB - 1);
        check(phase_o === e_ph, {"R2 phase ", ctx}, 128'(phase_o), 128'(e_ph));
        check(samp_en_o === e_s, {"R3 sampling ", ctx}, 128'(samp_en_o), 128'(e_s));
        if (m_tick == TK - 1)
            check(samp_en_o === '0, {"R4 guard tick ", ctx}, 128'(samp_en_o), 128'(0));
        check(amp_en_o === e_a, {"R5 amplify ", ctx}, 128'(amp_en_o), 128'(e_a));
        check(amp_rst_o === e_r, {"R6 amp reset ", ctx}, 128'(amp_rst_o), 128'(e_r));
        check(valid_o === e_v, {"R7 valid ", ctx}, 128'(valid_o), 128'(e_v));
    endtask

    task automatic step(input string ctx);
        @(negedge clk);
        model_step();
        compare(ctx);
    endtask

    // R1: reset state during reset and in the first clock after it
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        check(phase_o === 10'b0000000001, "R1 phase in reset", 128'(phase_o), 128'(1));
        check(amp_rst_o === 1'b1 && amp_en_o === '0 && valid_o === 1'b0,
              "R1 amp/valid in reset",
              128'({amp_rst_o, amp_en_o, valid_o}), 128'({1'b1, 10'b0, 1'b0}));
        compare("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        model_step();
        compare("R1 first clock");
    endtask

    // R7: warm-up edge and several full revolutions
    task automatic t_warmup_and_run();
        bit seen_valid;
        seen_valid = 0;
        for (int i = 0; i < 3 * NB * TK; i++) begin
            step("run");
            if (valid_o === 1'b1 && !seen_valid) begin
                seen_valid = 1;
                check(m_done == NB - 1 && m_tick == TK - 1, "R7 first valid position",
                      128'(m_done), 128'(NB - 1));
            end
        end
        check(seen_valid, "R7 valid ever seen", 128'(seen_valid), 128'(1));
    endtask

    // R8: inject an illegal ring state, expect slot 0 on the next clock
    task automatic t_illegal(input logic [NB-1:0] pat, input string ctx);
        @(negedge clk);
        model_step();
        compare(ctx);
        force i_interleave_phase_gen.u_ring.ring_q = pat;
        #1;
        release i_interleave_phase_gen.u_ring.ring_q;
        @(negedge clk);
        model_step();
        m_ph = 0;
        check(phase_o === 10'b0000000001, {"R8 repair ", ctx}, 128'(phase_o), 128'(1));
        compare({"R8 ", ctx});
        for (int i = 0; i < 2 * TK; i++) step({"R8 after ", ctx});
    endtask

    // R9: reset in the middle of operation restarts the warm-up
    task automatic t_midreset();
        for (int i = 0; i < 7; i++) step("R9 pre");
        t_reset();
        for (int i = 0; i < (NB - 1) * TK - 2; i++) begin
            step("R9 warmup");
            check(valid_o === 1'b0, "R9 no valid during warm-up", 128'(valid_o), 128'(0));
        end
        for (int i = 0; i < 2 * TK; i++) step("R9 post");
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_warmup_and_run();
        t_illegal(10'b0000000000, "all-zero ring");
        t_illegal(10'b0000100100, "two-hot ring");
        for (int i = 0; i < 3; i++) step("tick offset");
        t_illegal(10'b1111111111, "all-ones ring");
        t_midreset();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule